// File: doc/BRIEF.md
# Subhexagon Mapping and Reverse-Mapping Level Generator

This block sits between the sector-finding logic and the gate drivers of a four-level drive. The four levels come from two two-level inverters that feed an open-end winding from both ends. Once per sample it receives three inputs: the subhexagon centre nearest the reference, in 60-degree (m, n) coordinates; the basic sector number; and an over-modulation flag. It returns the reference shifted into the inner two-level hexagon, and it keeps the centre converted into per-phase level offsets.

During the sample, the PWM sequencer outside this block presents each two-level switching state in its optimum order. The block adds the stored offsets to that state to form the actual per-phase levels 0 to 3. It then splits each level into top-switch commands for the high-voltage inverter (two thirds of the link) and the low-voltage inverter (one third of the link). Each of the six legs drives a complementary top/bottom gate pair with a programmable dead band.

A per-phase sum outside 0 to 3 is flagged as an error and never reaches the gates. The last valid levels stay in place. In over-modulation the centre offset is dropped, so only the two-level states are applied.

Top module: `shm_level_mapper`

## Requirements
- R1: On a cycle with `smp_en` high, the block registers `ref_m - ctr_m` and `ref_n - ctr_n` (signed). They appear on `map_m` and `map_n` after that clock edge and hold until the next `smp_en`.
- R2: For sector codes 1 and 2, the stored per-phase offsets are a = m + n, b = n, c = 0, where (m, n) is the captured centre.
- R3: For sector codes 3 and 4, the stored offsets are a = 0, b = -m, c = -m - n.
- R4: For sector codes 5 and 6, the stored offsets are a = m, b = 0, c = -n. Sector codes 0 and 7 give all-zero offsets.
- R5: On a cycle with `tl_valid` high, each phase level becomes its offset plus its two-level bit. `tl_state` bit 0 is phase a, bit 1 is phase b and bit 2 is phase c. The levels appear on `lvl_o` after that edge: bits [1:0] hold a, [3:2] hold b and [5:4] hold c.
- R6: If `ovm` is high when the centre is captured, the offsets for that sample are zero, so the levels equal the two-level bits.
- R7: If any phase sum on a `tl_valid` cycle lies outside 0 to 3, `err_o` goes to 1 and `lvl_o` keeps its previous value. The next `tl_valid` with all sums in range clears `err_o`.
- R8: The top-switch commands for each phase are derived from its level. Level 0 gives inverter 1 off and inverter 2 on. Level 1 gives both off. Level 2 gives both on. Level 3 gives inverter 1 on and inverter 2 off.
- R9: The gates follow a change in `lvl_o` one clock later. On each command change, the leg drives both its top and bottom gates low for exactly `dead_cyc` cycles, then drives only the new side. Top and bottom are never high together.
- R10: After reset, `lvl_o` = 0, `err_o` = 0, `map_m` = `map_n` = 0, `inv1_lo` = 3'b111, `inv2_hi` = 3'b111, and the other gates are low.
- R11: Without `tl_valid`, `lvl_o` does not change, whatever `tl_state` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Capture centre, sector, over-modulation flag and reference |
| ctr_m | input | W | Subhexagon centre m coordinate (signed) |
| ctr_n | input | W | Subhexagon centre n coordinate (signed) |
| sector | input | 3 | Basic sector code 1..6 |
| ovm | input | 1 | Over-modulation: suppress centre offset |
| ref_m | input | W | Reference m coordinate (signed) |
| ref_n | input | W | Reference n coordinate (signed) |
| tl_valid | input | 1 | Apply the two-level state this cycle |
| tl_state | input | 3 | Two-level state, bit0=a, bit1=b, bit2=c |
| dead_cyc | input | DTW | Dead band length in cycles |
| map_m | output | W+1 | Mapped reference m |
| map_n | output | W+1 | Mapped reference n |
| lvl_o | output | 6 | Per-phase levels {c,b,a} |
| err_o | output | 1 | Last applied sum was out of range |
| inv1_hi | output | 3 | Inverter 1 top gates per phase |
| inv1_lo | output | 3 | Inverter 1 bottom gates per phase |
| inv2_hi | output | 3 | Inverter 2 top gates per phase |
| inv2_lo | output | 3 | Inverter 2 bottom gates per phase |

## Verification
The bench walks every sector pair with centres of both signs. A design that swapped the pairs or dropped a negation would return levels on the wrong phase or with the wrong sign. Two cases target the error path. One produces a sum of 4 and one produces a sum of -1; a design that wrapped the sum, or that updated the levels anyway, would send a legal-looking but wrong level to the gates. An over-modulation sample with a nonzero centre shows whether the offset is really suppressed. A dead-band run checks that a leg stays fully off for the programmed count and not one cycle more or less. Sector codes 0 and 7, and a `tl_state` change without `tl_valid`, check that nothing leaks through.

// File: rtl/shm_pkg.sv
package shm_pkg;
  // number of inverter phases
  localparam int unsigned NPH = 3;
  // width of one phase level (four levels)
  localparam int unsigned LVW = 2;
  // largest legal level value
  localparam int unsigned LVMAX = 3;
endpackage

// File: rtl/shm_centre_offset.sv
module shm_centre_offset #(
  parameter int unsigned W  = 4,
  parameter int unsigned OW = W + 2
) (
  input  logic signed [W-1:0]  cm,
  input  logic signed [W-1:0]  cn,
  input  logic        [2:0]    sec,
  input  logic                 ovm,
  output logic signed [OW-1:0] oa,
  output logic signed [OW-1:0] ob,
  output logic signed [OW-1:0] oc
);
  logic signed [OW-1:0] em, en;

  always_comb begin
    em = OW'(cm);
    en = OW'(cn);
    oa = '0;
    ob = '0;
    oc = '0;
    if (!ovm) begin
      unique case (sec)
        3'd1, 3'd2: begin oa = em + en; ob = en;  oc = '0;       end
        3'd3, 3'd4: begin oa = '0;      ob = -em; oc = -em - en; end
        3'd5, 3'd6: begin oa = em;      ob = '0;  oc = -en;      end
        default:    begin oa = '0;      ob = '0;  oc = '0;       end
      endcase
    end
  end
endmodule

// File: rtl/shm_phase_sum.sv
module shm_phase_sum
  import shm_pkg::*;
#(
  parameter int unsigned OW = 6
) (
  input  logic signed [OW-1:0] off,
  input  logic                 tl_bit,
  output logic        [LVW-1:0] lvl,
  output logic                 bad
);
  logic signed [OW:0] sum;

  always_comb begin
    sum = (OW+1)'(off) + $signed({{OW{1'b0}}, tl_bit});
    bad = (sum < 0) || (sum > $signed((OW+1)'(LVMAX)));
    lvl = sum[LVW-1:0];
  end
endmodule

// File: rtl/shm_deadband_leg.sv
module shm_deadband_leg #(
  parameter int unsigned DTW  = 4,
  parameter bit          INIT = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd,
  input  logic [DTW-1:0] dead,
  output logic           hi,
  output logic           lo
);
  logic           cmd_q, cmd_d;
  logic [DTW-1:0] cnt_q, cnt_d;

  always_comb begin
    cmd_d = cmd_q;
    cnt_d = cnt_q;
    if (cmd != cmd_q) begin
      cmd_d = cmd;
      cnt_d = dead;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= INIT;
      cnt_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
    end
  end

  assign hi = cmd_q  & (cnt_q == '0);
  assign lo = ~cmd_q & (cnt_q == '0);
endmodule

// File: rtl/shm_level_mapper.sv
module shm_level_mapper
  import shm_pkg::*;
#(
  parameter int unsigned W   = 4,
  parameter int unsigned DTW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_en,
  input  logic signed [W-1:0] ctr_m,
  input  logic signed [W-1:0] ctr_n,
  input  logic [2:0]          sector,
  input  logic                ovm,
  input  logic signed [W-1:0] ref_m,
  input  logic signed [W-1:0] ref_n,
  input  logic                tl_valid,
  input  logic [2:0]          tl_state,
  input  logic [DTW-1:0]      dead_cyc,
  output logic signed [W:0]   map_m,
  output logic signed [W:0]   map_n,
  output logic [5:0]          lvl_o,
  output logic                err_o,
  output logic [2:0]          inv1_hi,
  output logic [2:0]          inv1_lo,
  output logic [2:0]          inv2_hi,
  output logic [2:0]          inv2_lo
);
  localparam int unsigned OW  = W + 2;
  localparam int unsigned LTW = NPH * LVW;

  logic signed [OW-1:0] off_c [NPH];
  logic signed [OW-1:0] off_q [NPH];
  logic signed [OW-1:0] off_d [NPH];
  logic signed [W:0]    map_m_q, map_m_d, map_n_q, map_n_d;
  logic [LTW-1:0]       lvl_q, lvl_d, lvl_sum;
  logic [NPH-1:0]       bad;
  logic                 err_q, err_d;

  shm_centre_offset #(.W(W), .OW(OW)) u_off (
    .cm(ctr_m), .cn(ctr_n), .sec(sector), .ovm(ovm),
    .oa(off_c[0]), .ob(off_c[1]), .oc(off_c[2])
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    shm_phase_sum #(.OW(OW)) u_sum (
      .off(off_q[p]), .tl_bit(tl_state[p]),
      .lvl(lvl_sum[p*LVW +: LVW]), .bad(bad[p])
    );
    shm_deadband_leg #(.DTW(DTW), .INIT(1'b0)) u_leg1 (
      .clk(clk), .rst_n(rst_n), .cmd(lvl_q[p*LVW+1]), .dead(dead_cyc),
      .hi(inv1_hi[p]), .lo(inv1_lo[p])
    );
    shm_deadband_leg #(.DTW(DTW), .INIT(1'b1)) u_leg2 (
      .clk(clk), .rst_n(rst_n), .cmd(~lvl_q[p*LVW]), .dead(dead_cyc),
      .hi(inv2_hi[p]), .lo(inv2_lo[p])
    );
  end

  // next-state logic
  always_comb begin
    off_d   = off_q;
    map_m_d = map_m_q;
    map_n_d = map_n_q;
    lvl_d   = lvl_q;
    err_d   = err_q;
    if (smp_en) begin
      off_d   = off_c;
      map_m_d = (W+1)'(ref_m) - (W+1)'(ctr_m);
      map_n_d = (W+1)'(ref_n) - (W+1)'(ctr_n);
    end
    if (tl_valid) begin
      err_d = |bad;
      if (!(|bad)) lvl_d = lvl_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPH; p++) off_q[p] <= '0;
      map_m_q <= '0;
      map_n_q <= '0;
      lvl_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      off_q   <= off_d;
      map_m_q <= map_m_d;
      map_n_q <= map_n_d;
      lvl_q   <= lvl_d;
      err_q   <= err_d;
    end
  end

  assign map_m = map_m_q;
  assign map_n = map_n_q;
  assign lvl_o = lvl_q;
  assign err_o = err_q;
endmodule

// File: rtl/shm_level_mapper_chk.sv
module shm_level_mapper_chk #(
  parameter int unsigned W   = 4,
  parameter int unsigned DTW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_en,
  input logic signed [W-1:0] ctr_m,
  input logic signed [W-1:0] ref_m,
  input logic                tl_valid,
  input logic [DTW-1:0]      dead_cyc,
  input logic signed [W:0]   map_m,
  input logic [5:0]          lvl_o,
  input logic                err_o,
  input logic [2:0]          inv1_hi,
  input logic [2:0]          inv1_lo,
  input logic [2:0]          inv2_hi,
  input logic [2:0]          inv2_lo
);
  // R1: mapped coordinate follows a capture
  p_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> (map_m == ((W+1)'($past(ref_m)) - (W+1)'($past(ctr_m)))));

  // R11: no update strobe, no level change
  p_lvl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tl_valid |=> $stable(lvl_o));

  // R7: an error keeps the previous levels
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tl_valid ##1 err_o |-> $stable(lvl_o));

  // R9: never both gates of a leg on
  p_gate_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((inv1_hi & inv1_lo) == 3'b000) && ((inv2_hi & inv2_lo) == 3'b000));

  for (genvar p = 0; p < 3; p++) begin : g_dt
    // R9: a top gate turning on follows an all-off gap
    p_dead_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(inv1_hi[p]) && dead_cyc != '0 && $stable(dead_cyc))
        |-> !$past(inv1_lo[p]));
    p_dead_gap2_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(inv2_lo[p]) && dead_cyc != '0 && $stable(dead_cyc))
        |-> !$past(inv2_hi[p]));
  end
endmodule

bind shm_level_mapper shm_level_mapper_chk #(.W(W), .DTW(DTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ctr_m(ctr_m), .ref_m(ref_m),
  .tl_valid(tl_valid), .dead_cyc(dead_cyc), .map_m(map_m), .lvl_o(lvl_o),
  .err_o(err_o), .inv1_hi(inv1_hi), .inv1_lo(inv1_lo),
  .inv2_hi(inv2_hi), .inv2_lo(inv2_lo)
);

// File: tb/shm_level_mapper_bench.sv
module shm_level_mapper_bench;
  localparam int W = 4;
  localparam int DTW = 4;
  localparam int NV = 13;

  logic clk, rst_n, smp_en, ovm, tl_valid;
  logic signed [W-1:0] ctr_m, ctr_n, ref_m, ref_n;
  logic [2:0] sector, tl_state;
  logic [DTW-1:0] dead_cyc;
  logic signed [W:0] map_m, map_n;
  logic [5:0] lvl_o;
  logic err_o;
  logic [2:0] inv1_hi, inv1_lo, inv2_hi, inv2_lo;

  int n_chk = 0, n_fail = 0;

  shm_level_mapper #(.W(W), .DTW(DTW)) u_shm_level_mapper (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ctr_m(ctr_m), .ctr_n(ctr_n),
    .sector(sector), .ovm(ovm), .ref_m(ref_m), .ref_n(ref_n),
    .tl_valid(tl_valid), .tl_state(tl_state), .dead_cyc(dead_cyc),
    .map_m(map_m), .map_n(map_n), .lvl_o(lvl_o), .err_o(err_o),
    .inv1_hi(inv1_hi), .inv1_lo(inv1_lo), .inv2_hi(inv2_hi), .inv2_lo(inv2_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {sector, m, n, ovm, tl_state, lvl {c,b,a}, err}
  localparam logic [21:0] VEC [NV] = '{
    {3'd5, 4'h1, 4'hE, 1'b0, 3'b000, 2'd2, 2'd0, 2'd1, 1'b0}, // R4 centre 102
    {3'd5, 4'h1, 4'hE, 1'b0, 3'b001, 2'd2, 2'd0, 2'd2, 1'b0}, // R5 -> 202
    {3'd5, 4'h1, 4'hE, 1'b0, 3'b101, 2'd3, 2'd0, 2'd2, 1'b0}, // R5 -> 203
    {3'd1, 4'h1, 4'h1, 1'b0, 3'b111, 2'd1, 2'd2, 2'd3, 1'b0}, // R2
    {3'd2, 4'h0, 4'h1, 1'b0, 3'b000, 2'd0, 2'd1, 2'd1, 1'b0}, // R2
    {3'd3, 4'hF, 4'hF, 1'b0, 3'b000, 2'd2, 2'd1, 2'd0, 1'b0}, // R3
    {3'd4, 4'hE, 4'h1, 1'b0, 3'b010, 2'd1, 2'd3, 2'd0, 1'b0}, // R3
    {3'd6, 4'h2, 4'hF, 1'b0, 3'b110, 2'd2, 2'd1, 2'd2, 1'b0}, // R4
    {3'd1, 4'h2, 4'h1, 1'b0, 3'b001, 2'd2, 2'd1, 2'd2, 1'b1}, // R7 sum 4
    {3'd5, 4'hF, 4'h0, 1'b1, 3'b011, 2'd0, 2'd1, 2'd1, 1'b0}, // R6
    {3'd5, 4'hF, 4'h0, 1'b0, 3'b000, 2'd0, 2'd1, 2'd1, 1'b1}, // R7 sum -1
    {3'd0, 4'h3, 4'h3, 1'b0, 3'b100, 2'd1, 2'd0, 2'd0, 1'b0}, // R4 code 0
    {3'd7, 4'h1, 4'h1, 1'b0, 3'b111, 2'd1, 2'd1, 2'd1, 1'b0}  // R4 code 7
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] gates_for(input logic [5:0] l);
    logic [2:0] t1, t2;
    for (int p = 0; p < 3; p++) begin
      t1[p] = l[2*p+1];
      t2[p] = ~l[2*p];
    end
    return {t1, ~t1, t2, ~t2};
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_en = 0; ovm = 0; tl_valid = 0; tl_state = '0;
    ctr_m = '0; ctr_n = '0; ref_m = '0; ref_n = '0; sector = 3'd1;
    dead_cyc = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 lvl", int'(lvl_o), 0);
    chk("R10 err", int'(err_o), 0);
    chk("R10 map", int'(map_m) + int'(map_n), 0);
    chk("R10 gates", int'({inv1_hi, inv1_lo, inv2_hi, inv2_lo}),
        int'({3'b000, 3'b111, 3'b111, 3'b000}));
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2..R8
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      sector = v[21:19]; ctr_m = v[18:15]; ctr_n = v[14:11]; ovm = v[10];
      ref_m = ctr_m + 4'sd2; ref_n = ctr_n - 4'sd1;
      smp_en = 1;
      @(negedge clk);
      smp_en = 0;
      // R1 mapped reference
      chk($sformatf("R1 map_m v%0d", i), int'(map_m), 2);
      chk($sformatf("R1 map_n v%0d", i), int'(map_n), -1);
      tl_state = v[9:7]; tl_valid = 1;
      @(negedge clk);
      tl_valid = 0;
      chk($sformatf("R5 lvl v%0d", i), int'(lvl_o), int'(v[6:1]));
      chk($sformatf("R7 err v%0d", i), int'(err_o), int'(v[0]));
      @(negedge clk);
      chk($sformatf("R8 gates v%0d", i),
          int'({inv1_hi, inv1_lo, inv2_hi, inv2_lo}), int'(gates_for(v[6:1])));
    end

    // R11: tl_state moves without tl_valid
    tl_state = 3'b000;
    repeat (2) @(negedge clk);
    chk("R11 hold", int'(lvl_o), int'({2'd1, 2'd1, 2'd1}));

    // R9 dead band: sector 5, centre (0,0) -> all zero offsets
    rst_n = 0; @(negedge clk); rst_n = 1;
    dead_cyc = 4'd3;
    sector = 3'd5; ctr_m = '0; ctr_n = '0; ovm = 0; smp_en = 1;
    @(negedge clk);
    smp_en = 0;
    tl_state = 3'b001; tl_valid = 1;   // phase a level 0 -> 1, inv2 a top on->off
    @(negedge clk);
    tl_valid = 0;
    chk("R9 before change hi", int'(inv2_hi[0]), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk($sformatf("R9 gap%0d", k), int'({inv2_hi[0], inv2_lo[0]}), 0);
    end
    @(negedge clk);
    chk("R9 after gap lo", int'({inv2_hi[0], inv2_lo[0]}), 1);
    chk("R9 untouched leg", int'({inv1_hi[0], inv1_lo[0]}), 1);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule